// File: doc/BRIEF.md
# I2C Ten-Bit Address Slave Receiver

This block is the receive side of an I2C slave that answers to a ten-bit address and then takes data bytes written by a bus master. It runs on the system clock and oversamples SCL and SDA through two-flop synchronisers. START and STOP are found from SDA edges while SCL is high. Bits are shifted in on SCL rising edges, and the block pulls SDA low for the ninth (acknowledge) clock of every byte it accepts.

The address is checked in two steps with help from a host. The host first loads the match register with the high address byte. When that byte has been acknowledged, the block raises an update flag and holds SCL low. The host must then write the low address byte into the match register. That write clears the flag and releases SCL. After the second byte is acknowledged the flag rises again, and the host puts the high byte back. Every accepted byte, address bytes included, is placed in a one-byte receive buffer. A byte that completes while the buffer is still full is refused and recorded as an overflow.

The host port is a plain register port with three addresses:
- 0: receive buffer. A read clears the full flag.
- 1: match register.
- 2: status. Reads return the flags; a write clears sticky flags.

Top module: `i2c10_slave_rx`

## Requirements
- R1: After reset, scl_oe and sda_oe are 0 and the status register (address 2) reads 0x00.
- R2: A first byte after START is accepted only if bits 7..3 are 11110, bits 2..1 equal match register bits 2..1 and bit 0 (R/W) is 0. Any other first byte gets no ACK (sda_oe stays 0), and every following byte is ignored until the next START.
- R3: After an accepted address byte, status bit 1 (update) is set within a few cycles of the ninth SCL falling edge and scl_oe is driven to 1. Data bytes never set it.
- R4: The update flag and scl_oe stay at 1 until the host writes address 1. That write clears both.
- R5: The second address byte is acknowledged only when it equals the whole match register. On a match, status bit 5 (data phase) is set. On a mismatch there is no ACK and no update flag.
- R6: Each accepted byte is acknowledged, copied into the buffer at address 0, and sets status bit 0 (full) and bit 2 (interrupt).
- R7: A host read of address 0 returns the buffer and clears the full flag.
- R8: A byte that completes while full is set gets no ACK, sets status bit 3 (overflow), and leaves the buffer contents unchanged.
- R9: The interrupt, overflow and stop bits are cleared only by writing 1 to bits 2, 3 and 4 of address 2. Buffer reads and match writes leave them alone.
- R10: A STOP sets status bit 4 and returns the receiver to idle, which clears bit 5. Clock pulses after a STOP without a new START are not acknowledged and change nothing in the buffer.
- R11: A START seen in the middle of a transfer restarts the address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled SCL bus line |
| sda_in | input | 1 | Sampled SDA bus line |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | 2 | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data (combinational) |

## Verification
Every bus event reaches the control logic three system clocks after the line changes: two synchroniser stages plus one edge-detect stage. The ACK drive therefore appears about four cycles after the eighth SCL falling edge. The update flag, and with it the stretch, appears about four cycles after the ninth falling edge. The bench keeps SCL low for eight cycles and high for at least eight. It samples the acknowledge in the middle of the ninth high phase and reads the status only once the low phase that follows has run its full length. Register reads are combinational and are sampled one time step after the strobe is set. Their side effects, such as clearing the full flag, act on the next rising edge, so the next read observes them.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;
  localparam int unsigned REG_AW = 2;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_HI,
    RX_LO,
    RX_DATA,
    RX_SKIP
  } rx_state_e;

  localparam logic [REG_AW-1:0] RA_BUF   = 2'd0;
  localparam logic [REG_AW-1:0] RA_MATCH = 2'd1;
  localparam logic [REG_AW-1:0] RA_STAT  = 2'd2;

  localparam int unsigned SB_FULL = 0;
  localparam int unsigned SB_UPD  = 1;
  localparam int unsigned SB_IRQ  = 2;
  localparam int unsigned SB_OVF  = 3;
  localparam int unsigned SB_STOP = 4;
  localparam int unsigned SB_DATA = 5;

  localparam logic [4:0] HI_PREFIX = 5'b11110;
endpackage

// File: rtl/i2c10_sync.sv
module i2c10_sync #(
  parameter int unsigned LINES  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout,
  output logic [LINES-1:0] dprev
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES:0] pipe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '1;
      else        pipe_q <= {pipe_q[STAGES-1:0], din[g]};
    end
    assign dout[g]  = pipe_q[STAGES-1];
    assign dprev[g] = pipe_q[STAGES];
  end
endmodule

// File: rtl/i2c10_shift.sv
module i2c10_shift #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              restart,
  input  logic              sda,
  output logic              done,
  output logic              slot_end,
  output logic              ack_slot,
  output logic [BYTE_W-1:0] byte_now
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] C_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] C_WAIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] C_SLOT = CNT_W'(BYTE_W + 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;

  assign byte_now = {sh_q[BYTE_W-2:0], sda};
  assign done     = !restart && scl_rise && (cnt_q == C_LAST);
  assign slot_end = !restart && scl_fall && (cnt_q == C_SLOT);
  assign ack_slot = (cnt_q == C_SLOT);

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    if (restart) begin
      cnt_d = '0;
    end else if (scl_rise && (cnt_q < C_WAIT)) begin
      sh_d  = byte_now;
      cnt_d = cnt_q + 1'b1;
    end else if (scl_fall && (cnt_q == C_WAIT)) begin
      cnt_d = C_SLOT;
    end else if (scl_fall && (cnt_q == C_SLOT)) begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end
endmodule

// File: rtl/i2c10_ctrl.sv
module i2c10_ctrl
  import i2c10_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              done,
  input  logic              slot_end,
  input  logic [BYTE_W-1:0] byte_now,
  input  logic [BYTE_W-1:0] match,
  input  logic              rd_buf,
  input  logic              wr_match,
  input  logic [2:0]        clr_flags,
  output logic [BYTE_W-1:0] rx_buf,
  output logic              full,
  output logic              upd,
  output logic              irq,
  output logic              ovf,
  output logic              stop_seen,
  output logic              data_phase,
  output logic              ack_arm,
  output logic              take,
  output logic              store
);
  rx_state_e state_q, state_d;
  logic ack_q, ack_d, full_q, full_d, upd_q, upd_d;
  logic irq_q, irq_d, ovf_q, ovf_d, stp_q, stp_d, hit;
  logic [BYTE_W-1:0] buf_q;

  always_comb begin
    case (state_q)
      RX_HI:   hit = (byte_now[BYTE_W-1 -: 5] == HI_PREFIX) &&
                     (byte_now[BYTE_W-1:1] == match[BYTE_W-1:1]) && !byte_now[0];
      RX_LO:   hit = (byte_now == match);
      RX_DATA: hit = 1'b1;
      default: hit = 1'b0;
    endcase
  end

  assign take  = done && hit;
  assign store = take && !full_q;

  always_comb begin
    state_d = state_q;
    if (stop_ev)       state_d = RX_IDLE;
    else if (start_ev) state_d = RX_HI;
    else if (slot_end) begin
      case (state_q)
        RX_HI:   state_d = ack_q ? RX_LO   : RX_SKIP;
        RX_LO:   state_d = ack_q ? RX_DATA : RX_SKIP;
        default: state_d = state_q;
      endcase
    end

    if (start_ev || stop_ev) ack_d = 1'b0;
    else if (done)           ack_d = store;
    else if (slot_end)       ack_d = 1'b0;
    else                     ack_d = ack_q;

    if (slot_end && ack_q && ((state_q == RX_HI) || (state_q == RX_LO))) upd_d = 1'b1;
    else if (wr_match) upd_d = 1'b0;
    else               upd_d = upd_q;

    if (store)       full_d = 1'b1;
    else if (rd_buf) full_d = 1'b0;
    else             full_d = full_q;

    irq_d = take | (irq_q & ~clr_flags[0]);
    ovf_d = (take & full_q) | (ovf_q & ~clr_flags[1]);
    stp_d = stop_ev | (stp_q & ~clr_flags[2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      ack_q   <= 1'b0;
      upd_q   <= 1'b0;
      full_q  <= 1'b0;
      irq_q   <= 1'b0;
      ovf_q   <= 1'b0;
      stp_q   <= 1'b0;
      buf_q   <= '0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
      upd_q   <= upd_d;
      full_q  <= full_d;
      irq_q   <= irq_d;
      ovf_q   <= ovf_d;
      stp_q   <= stp_d;
      if (store) buf_q <= byte_now;
    end
  end

  assign rx_buf     = buf_q;
  assign full       = full_q;
  assign upd        = upd_q;
  assign irq        = irq_q;
  assign ovf        = ovf_q;
  assign stop_seen  = stp_q;
  assign data_phase = (state_q == RX_DATA);
  assign ack_arm    = ack_q;
endmodule

// File: rtl/i2c10_slave_rx.sv
module i2c10_slave_rx
  import i2c10_pkg::*;
#(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata
);
  logic [1:0] line_s, line_p;
  logic scl_s, scl_p, sda_s, sda_p;
  logic scl_rise, scl_fall, start_c, stop_c;
  logic done, slot_end, ack_slot;
  logic [BYTE_W-1:0] byte_now, match_q, rx_buf, stat;
  logic full_q, upd_q, irq_q, ovf_q, stop_q, data_ph, ack_arm, take, store;
  logic rd_buf, wr_match, wr_stat;
  logic [2:0] clr_flags;

  i2c10_sync #(.LINES(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .din({sda_in, scl_in}), .dout(line_s), .dprev(line_p)
  );

  assign scl_s    = line_s[0];
  assign scl_p    = line_p[0];
  assign sda_s    = line_s[1];
  assign sda_p    = line_p[1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_c  = scl_s & scl_p & ~sda_s & sda_p;
  assign stop_c   = scl_s & scl_p & sda_s & ~sda_p;

  i2c10_shift #(.BYTE_W(BYTE_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .restart(start_c | stop_c), .sda(sda_s), .done(done), .slot_end(slot_end),
    .ack_slot(ack_slot), .byte_now(byte_now)
  );

  assign rd_buf    = reg_rd && (reg_addr == RA_BUF);
  assign wr_match  = reg_wr && (reg_addr == RA_MATCH);
  assign wr_stat   = reg_wr && (reg_addr == RA_STAT);
  assign clr_flags = wr_stat ? {reg_wdata[SB_STOP], reg_wdata[SB_OVF], reg_wdata[SB_IRQ]} : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        match_q <= '0;
    else if (wr_match) match_q <= reg_wdata;
  end

  i2c10_ctrl #(.BYTE_W(BYTE_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_ev(start_c), .stop_ev(stop_c), .done(done),
    .slot_end(slot_end), .byte_now(byte_now), .match(match_q), .rd_buf(rd_buf),
    .wr_match(wr_match), .clr_flags(clr_flags), .rx_buf(rx_buf), .full(full_q),
    .upd(upd_q), .irq(irq_q), .ovf(ovf_q), .stop_seen(stop_q), .data_phase(data_ph),
    .ack_arm(ack_arm), .take(take), .store(store)
  );

  assign scl_oe = upd_q;
  assign sda_oe = ack_arm && ack_slot;

  always_comb begin
    stat          = '0;
    stat[SB_FULL] = full_q;
    stat[SB_UPD]  = upd_q;
    stat[SB_IRQ]  = irq_q;
    stat[SB_OVF]  = ovf_q;
    stat[SB_STOP] = stop_q;
    stat[SB_DATA] = data_ph;
    case (reg_addr)
      RA_BUF:   reg_rdata = rx_buf;
      RA_MATCH: reg_rdata = match_q;
      RA_STAT:  reg_rdata = stat;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2c10_slave_rx_chk.sv
module i2c10_slave_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic upd,
  input logic wr_match,
  input logic scl_oe,
  input logic sda_oe,
  input logic scl_sync,
  input logic rd_buf,
  input logic store,
  input logic take,
  input logic full,
  input logic ovf,
  input logic stop_c,
  input logic data_phase
);
  a_r4_update_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !wr_match) |=> upd);

  a_r4_write_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && wr_match) |=> (!upd && !scl_oe));

  a_r7_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_buf && !store) |=> !full);

  a_r8_full_sets_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && take) |=> ovf);

  a_r2_ack_starts_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_sync);

  a_r10_stop_leaves_data: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !data_phase);
endmodule

bind i2c10_slave_rx i2c10_slave_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .upd(upd_q), .wr_match(wr_match), .scl_oe(scl_oe),
  .sda_oe(sda_oe), .scl_sync(scl_s), .rd_buf(rd_buf), .store(store), .take(take),
  .full(full_q), .ovf(ovf_q), .stop_c(stop_c), .data_phase(data_ph)
);

// File: tb/i2c10_slave_rx_tb_top.sv
module i2c10_slave_rx_tb_top;
  import i2c10_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_line, sda_line, scl_oe, sda_oe;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0, reg_rdata;
  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];

  assign scl_line = m_scl & ~scl_oe;
  assign sda_line = m_sda & ~sda_oe;

  i2c10_slave_rx dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic scl_high();
    m_scl = 1'b1;
    while (!scl_line) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(HALF);
    scl_high(); tick(HALF);
    m_sda = 1'b0; tick(HALF);
    m_scl = 1'b0; tick(HALF);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(HALF);
    scl_high(); tick(HALF);
    m_sda = 1'b1; tick(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(HALF);
      scl_high(); tick(HALF);
      m_scl = 1'b0; tick(2);
    end
    m_sda = 1'b1; tick(HALF);
    scl_high(); tick(HALF/2);
    acked = !sda_line;
    tick(HALF/2);
    m_scl = 1'b0; tick(HALF);
  endtask

  // driver: pushes the byte the buffer must hold when accepted
  task automatic drive(input logic [7:0] b, input bit accept, input bit exp_ack, input string req);
    bit a;
    if (accept) exp_q.push_back(b);
    send_byte(b, a);
    chk(a == exp_ack, req, int'(a), int'(exp_ack));
  endtask

  // monitor: pops the oldest expected byte and compares the buffer
  task automatic check_buf(input string req);
    logic [7:0] d, e;
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
    host_read(RA_BUF, d);
    chk(d === e, req, int'(d), int'(e));
  endtask

  task automatic check_stat(input logic [7:0] e, input string req);
    logic [7:0] d;
    host_read(RA_STAT, d);
    chk(d === e, req, int'(d), int'(e));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(2);
    chk(!scl_oe && !sda_oe, "R1 outputs released", int'({scl_oe, sda_oe}), 0);
    check_stat(8'h00, "R1 status after reset");

    host_write(RA_MATCH, 8'hF2);
    bus_start();
    drive(8'hF2, 1'b1, 1'b1, "R2 high address ack");
    check_stat(8'h07, "R3 update flag after high byte");
    chk(scl_oe == 1'b1, "R3 stretch after high byte", int'(scl_oe), 1);
    check_buf("R6 high address byte in buffer");
    tick(20);
    chk(scl_oe && !scl_line, "R4 stretch held until write", int'(scl_line), 0);
    host_write(RA_MATCH, 8'hA5);
    chk(scl_oe == 1'b0, "R4 write releases SCL", int'(scl_oe), 0);
    check_stat(8'h04, "R4 R9 update cleared irq kept");
    host_write(RA_STAT, 8'h04);

    drive(8'hA5, 1'b1, 1'b1, "R5 low address ack");
    check_stat(8'h27, "R3 R5 update and data phase");
    check_buf("R6 low address byte in buffer");
    host_write(RA_MATCH, 8'hF2);
    check_stat(8'h24, "R5 data phase after restore");

    drive(8'h3C, 1'b1, 1'b1, "R6 data ack");
    chk(scl_oe == 1'b0, "R3 no stretch on data", int'(scl_oe), 0);
    check_stat(8'h25, "R6 full and irq");
    check_buf("R6 R7 data byte");
    check_stat(8'h24, "R7 read cleared full");

    drive(8'h81, 1'b1, 1'b1, "R6 data ack 2");
    drive(8'h55, 1'b0, 1'b0, "R8 nack on full buffer");
    check_stat(8'h2D, "R8 overflow set");
    check_buf("R8 buffer kept old byte");
    check_stat(8'h2C, "R9 overflow survives read");
    host_write(RA_STAT, 8'h0C);
    check_stat(8'h20, "R9 write clears irq and overflow");

    bus_stop();
    check_stat(8'h10, "R10 stop flag and idle");
    m_scl = 1'b0; tick(HALF);
    drive(8'h77, 1'b0, 1'b0, "R10 ignored without start");
    check_stat(8'h10, "R10 nothing stored after stop");
    host_write(RA_STAT, 8'h10);

    bus_start();
    drive(8'hF4, 1'b0, 1'b0, "R2 wrong high bits nack");
    drive(8'h11, 1'b0, 1'b0, "R2 later byte ignored");
    check_stat(8'h00, "R2 no flags after mismatch");
    bus_start();
    drive(8'hF3, 1'b0, 1'b0, "R2 read direction refused");
    chk(scl_oe == 1'b0, "R2 no stretch on refusal", int'(scl_oe), 0);

    bus_start();
    drive(8'hF2, 1'b1, 1'b1, "R2 address again");
    check_buf("R6 address again");
    host_write(RA_MATCH, 8'hA5);
    drive(8'hA5, 1'b1, 1'b1, "R5 low again");
    check_buf("R6 low again");
    host_write(RA_MATCH, 8'hF2);
    drive(8'h12, 1'b1, 1'b1, "R6 data again");
    check_buf("R6 data again");
    bus_start();
    drive(8'hF2, 1'b1, 1'b1, "R11 restart address ack");
    check_stat(8'h07, "R11 back in address phase");
    check_buf("R11 restart byte");
    host_write(RA_MATCH, 8'hA5);
    drive(8'h00, 1'b0, 1'b0, "R5 low mismatch nack");
    check_stat(8'h04, "R5 no update on mismatch");
    chk(scl_oe == 1'b0, "R5 no stretch on mismatch", int'(scl_oe), 0);
    bus_stop();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule